// File: doc/BRIEF.md
# Strobe-Phased Six-Read Three-Write Register File

This block is a register array for a datapath with three processing units. Each unit gets two read ports and one write port. The read ports come in pairs (A and B), and pair `p` shares its address buses with write port `p`. A single `strobe` input paces every access. While `strobe` is low the array stands in its precharge phase: no word is selected, nothing is read and nothing is written. When `strobe` rises, the `wr_mode` input fixes the kind of window. A window either reads on all six ports or writes on all three ports; it never mixes the two.

The access itself happens once, on the first clock edge of each strobe-high window. In a read window, each of the six addresses returns its own word. Several ports may name the same word. The read outputs are registered and keep their value until the next read window. In a write window, port `p` stores its data word at the address on its A bus, and its B bus plays no part.

When two or more write ports aim at one address, the lowest-numbered port wins and the others are dropped. A one-cycle `collision` pulse reports the event. If the mode or any address moves while the strobe is still high, the sticky flag `proto_err` is set.

Top module: `phased_regfile`

## Requirements
- R1: In a read window, every one of the six read outputs (`rdata_a[p]`, `rdata_b[p]`, each a WIDTH-bit slice at bit `p*WIDTH`) shows the word stored at its own address. The new value is visible after the first clock edge of the window.
- R2: In a write window, every write port `p` whose address is not shared with a lower-numbered port stores `wdata[p]` at `addr_a[p]`. Up to three distinct words are written in the same window.
- R3: During a write window the B address buses (`addr_b`) have no effect on which words are written.
- R4: The mode is taken from `wr_mode` (1 = write, 0 = read) on the first edge of a window. A write window leaves all read outputs unchanged, and a read window leaves the array unchanged.
- R5: Any number of read ports may name the same address in one read window, and each of them returns that word.
- R6: When several write ports carry the same address, only the lowest-numbered one is stored. `collision` is high for exactly the one cycle after the first edge of that window and is low otherwise.
- R7: While `strobe` is low, changes to the addresses, the data or the mode neither alter the array nor change any read output.
- R8: A change of `wr_mode` or of any address bus while `strobe` stays high sets `proto_err`. Once set, it stays set until reset.
- R9: After reset all words read as zero, every read output is zero, and `collision` and `proto_err` are low.
- R10: Only the first edge of a window performs the access. Changes to `wdata` later in the same window are not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | High: decode/access phase; low: precharge phase |
| wr_mode | input | 1 | 1 selects a write window, 0 a read window; sampled when strobe rises |
| addr_a | input | NP*AW | A-bus addresses, one per port pair; also the write addresses |
| addr_b | input | NP*AW | B-bus addresses, one per port pair |
| wdata | input | NP*WIDTH | Write data, one word per write port |
| rdata_a | output | NP*WIDTH | Read data from the A ports |
| rdata_b | output | NP*WIDTH | Read data from the B ports |
| collision | output | 1 | One-cycle pulse: write ports shared an address |
| proto_err | output | 1 | Sticky: mode or address moved while strobe was high |

## Verification
Two functions can fall in the same cycle: the write arbitration that drops colliding ports, and the storing of the winning ports' data. Both happen on the first edge of a write window. With a 16-word array, random addresses on three ports produce frequent collisions. The bench applies such windows alongside directed all-same-address windows. Its reference model stores only the first port to claim each address, and later read windows show whether the array kept exactly the winner's word. The `collision` pulse is compared in that same cycle.

// File: rtl/rf_pkg.sv
package rf_pkg;
  typedef enum logic {MODE_READ = 1'b0, MODE_WRITE = 1'b1} rf_mode_e;

  function automatic logic phase_rise(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction
endpackage

// File: rtl/rf_phase_seq.sv
module rf_phase_seq
  import rf_pkg::*;
#(
  parameter int NP = 3,
  parameter int AW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic             wr_mode,
  input  logic [NP*AW-1:0] addr_a,
  input  logic [NP*AW-1:0] addr_b,
  output logic             rise,
  output logic             proto_err
);
  logic             strobe_q;
  rf_mode_e         mode_q;
  logic [NP*AW-1:0] a_q, b_q;
  logic             in_hold, drift;

  assign rise    = phase_rise(strobe, strobe_q);
  assign in_hold = strobe & strobe_q;
  assign drift   = (wr_mode != logic'(mode_q)) || (addr_a != a_q) || (addr_b != b_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q  <= 1'b0;
      mode_q    <= MODE_READ;
      a_q       <= '0;
      b_q       <= '0;
      proto_err <= 1'b0;
    end else begin
      strobe_q <= strobe;
      if (rise) begin
        mode_q <= rf_mode_e'(wr_mode);
        a_q    <= addr_a;
        b_q    <= addr_b;
      end
      if (in_hold && drift) proto_err <= 1'b1;
    end
  end

  // R8
  proto_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);
  // R8
  proto_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !proto_err ##1 proto_err |-> $past(strobe));
endmodule

// File: rtl/rf_write_arb.sv
module rf_write_arb #(
  parameter int NP = 3,
  parameter int AW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [NP*AW-1:0] waddr,
  output logic [NP-1:0]    grant,
  output logic             clash
);
  always_comb begin
    for (int j = 0; j < NP; j++) begin
      grant[j] = fire;
      for (int i = 0; i < j; i++)
        if (waddr[i*AW +: AW] == waddr[j*AW +: AW]) grant[j] = 1'b0;
    end
    clash = fire && (grant != {NP{1'b1}});
  end

  // R6
  lowest_port_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> grant[0]);

  for (genvar i = 0; i < NP; i++) begin : g_pi
    for (genvar j = i + 1; j < NP; j++) begin : g_pj
      // R6
      wr_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[i] && grant[j]) |-> (waddr[i*AW +: AW] != waddr[j*AW +: AW]));
    end
  end
endmodule

// File: rtl/rf_store.sv
module rf_store #(
  parameter int NP    = 3,
  parameter int AW    = 4,
  parameter int WIDTH = 16,
  parameter int DEPTH = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NP-1:0]         we,
  input  logic [NP*AW-1:0]      waddr,
  input  logic [NP*WIDTH-1:0]   wdata,
  input  logic                  re,
  input  logic [2*NP*AW-1:0]    raddr,
  output logic [2*NP*WIDTH-1:0] rdata
);
  localparam int NR = 2 * NP;

  logic [WIDTH-1:0] mem [DEPTH];

  function automatic logic [WIDTH-1:0] fetch(input logic [AW-1:0] a);
    return (int'(a) < DEPTH) ? mem[a] : '0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else begin
      for (int p = 0; p < NP; p++)
        if (we[p] && int'(waddr[p*AW +: AW]) < DEPTH)
          mem[waddr[p*AW +: AW]] <= wdata[p*WIDTH +: WIDTH];
    end
  end

  for (genvar r = 0; r < NR; r++) begin : g_rd
    always_ff @(posedge clk) begin
      if (!rst_n) rdata[r*WIDTH +: WIDTH] <= '0;
      else if (re) rdata[r*WIDTH +: WIDTH] <= fetch(raddr[r*AW +: AW]);
    end
  end
endmodule

// File: rtl/phased_regfile.sv
module phased_regfile
  import rf_pkg::*;
#(
  parameter int NP    = 3,
  parameter int WIDTH = 16,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                strobe,
  input  logic                wr_mode,
  input  logic [NP*AW-1:0]    addr_a,
  input  logic [NP*AW-1:0]    addr_b,
  input  logic [NP*WIDTH-1:0] wdata,
  output logic [NP*WIDTH-1:0] rdata_a,
  output logic [NP*WIDTH-1:0] rdata_b,
  output logic                collision,
  output logic                proto_err
);
  logic          rise, rd_fire, wr_fire, clash;
  logic [NP-1:0] grant;

  assign rd_fire = rise && (wr_mode == MODE_READ);
  assign wr_fire = rise && (wr_mode == MODE_WRITE);

  rf_phase_seq #(.NP(NP), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wr_mode(wr_mode),
    .addr_a(addr_a), .addr_b(addr_b), .rise(rise), .proto_err(proto_err)
  );

  rf_write_arb #(.NP(NP), .AW(AW)) u_arb (
    .clk(clk), .rst_n(rst_n), .fire(wr_fire), .waddr(addr_a),
    .grant(grant), .clash(clash)
  );

  rf_store #(.NP(NP), .AW(AW), .WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .we(grant), .waddr(addr_a), .wdata(wdata),
    .re(rd_fire), .raddr({addr_b, addr_a}), .rdata({rdata_b, rdata_a})
  );

  always_ff @(posedge clk) begin
    if (!rst_n) collision <= 1'b0;
    else        collision <= clash;
  end

  // R6
  clash_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    collision |=> !collision);
  // R7
  idle_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |-> (!rd_fire && grant == '0));
  // R4
  no_mixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_fire && (grant != '0)));
  // R4
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> ($stable(rdata_a) && $stable(rdata_b)));
endmodule

// File: tb/phased_regfile_bench.sv
`timescale 1ns/1ps
module phased_regfile_bench;
  localparam int NP = 3, W = 16, DEPTH = 16, AW = 4;

  logic clk = 1'b0, rst_n = 1'b0, strobe = 1'b0, wr_mode = 1'b0;
  logic [NP*AW-1:0] addr_a = '0, addr_b = '0;
  logic [NP*W-1:0]  wdata = '0;
  logic [NP*W-1:0]  rdata_a, rdata_b;
  logic             collision, proto_err;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [W-1:0] model [DEPTH];

  always #10 clk = ~clk;

  phased_regfile #(.NP(NP), .WIDTH(W), .DEPTH(DEPTH)) u_phased_regfile (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wr_mode(wr_mode),
    .addr_a(addr_a), .addr_b(addr_b), .wdata(wdata),
    .rdata_a(rdata_a), .rdata_b(rdata_b), .collision(collision), .proto_err(proto_err)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected clash: fewer distinct write addresses than ports
  function automatic bit exp_clash(input logic [NP*AW-1:0] aa);
    bit [DEPTH-1:0] seen = '0;
    int n = 0;
    for (int p = 0; p < NP; p++) begin
      if (!seen[aa[p*AW +: AW]]) n++;
      seen[aa[p*AW +: AW]] = 1'b1;
    end
    return n < NP;
  endfunction

  // store in reverse so the lowest port overwrites the rest
  task automatic model_write(input logic [NP*AW-1:0] aa, input logic [NP*W-1:0] wd);
    for (int p = NP - 1; p >= 0; p--) model[aa[p*AW +: AW]] = wd[p*W +: W];
  endtask

  task automatic window(input bit wm, input logic [NP*AW-1:0] aa, input logic [NP*AW-1:0] ab,
                        input logic [NP*W-1:0] wd, input string tag);
    logic [NP*W-1:0] pa, pb;
    bit ec;
    @(negedge clk);
    pa = rdata_a; pb = rdata_b;
    strobe = 1'b1; wr_mode = wm; addr_a = aa; addr_b = ab; wdata = wd;
    @(negedge clk);
    if (wm) begin
      ec = exp_clash(aa);
      model_write(aa, wd);
      chk(rdata_a == pa && rdata_b == pb, {tag, " R4 write window holds rdata"}, rdata_a, pa);
      chk(collision == ec, {tag, " R6 collision pulse"}, collision, ec);
    end else begin
      for (int p = 0; p < NP; p++) begin
        chk(rdata_a[p*W +: W] == model[aa[p*AW +: AW]], {tag, " R1 read A"},
            rdata_a[p*W +: W], model[aa[p*AW +: AW]]);
        chk(rdata_b[p*W +: W] == model[ab[p*AW +: AW]], {tag, " R1 read B"},
            rdata_b[p*W +: W], model[ab[p*AW +: AW]]);
      end
      chk(collision == 1'b0, {tag, " R6 no collision on read"}, collision, 0);
    end
    @(negedge clk);
    chk(collision == 1'b0, {tag, " R6 pulse one cycle"}, collision, 0);
    strobe = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NP*AW-1:0] ra, rb;
    logic [NP*W-1:0] rw, hold_a;
    void'($urandom(32'd24680));
    for (int k = 0; k < DEPTH; k++) model[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(rdata_a == '0 && rdata_b == '0, "R9 rdata after reset", rdata_a, 0);
    chk(collision == 1'b0 && proto_err == 1'b0, "R9 flags after reset", {collision, proto_err}, 0);
    window(1'b0, 12'hF73, 12'h1A0, '0, "R9 words zero");

    // R2 three distinct writes; R3 B bus garbage
    window(1'b1, 12'h521, 12'hBBB, 48'hCCCC_BBBB_AAAA, "R2 R3 distinct");
    window(1'b0, 12'h521, 12'hB00, '0, "R2 R3 readback");

    // R6 all three ports on one address: port 0 wins
    window(1'b1, 12'h999, 12'h123, 48'h3333_2222_1111, "R6 triple");
    window(1'b0, 12'h999, 12'h999, '0, "R5 R6 same addr all ports");
    chk(rdata_a[W-1:0] == 16'h1111, "R6 port0 word kept", rdata_a[W-1:0], 16'h1111);

    // R7 activity while strobe low has no effect
    @(negedge clk);
    hold_a = rdata_a;
    wr_mode = 1'b1; addr_a = 12'h999; wdata = 48'hDEAD_DEAD_DEAD;
    repeat (3) @(negedge clk);
    chk(rdata_a == hold_a, "R7 rdata stable while precharge", rdata_a, hold_a);
    window(1'b0, 12'h999, 12'h521, '0, "R7 array untouched");

    // R10 wdata change late in window ignored
    @(negedge clk);
    strobe = 1'b1; wr_mode = 1'b1; addr_a = 12'h876; addr_b = 12'h876; wdata = 48'h0C0C_0B0B_0A0A;
    @(negedge clk);
    model_write(12'h876, 48'h0C0C_0B0B_0A0A);
    wdata = 48'hFFFF_FFFF_FFFF;
    repeat (2) @(negedge clk);
    strobe = 1'b0;
    @(negedge clk);
    window(1'b0, 12'h876, 12'h876, '0, "R10 late wdata");
    chk(proto_err == 1'b0, "R8 no error on data change", proto_err, 0);

    // random mix
    for (int n = 0; n < 300; n++) begin
      ra = NP*AW'($urandom()); rb = NP*AW'($urandom()); rw = NP*W'({$urandom(), $urandom()});
      window(1'($urandom() % 2), ra, rb, rw, "RND");
    end

    // R8 address moved while strobe high
    @(negedge clk);
    strobe = 1'b1; wr_mode = 1'b0; addr_a = 12'h111; addr_b = 12'h222;
    @(negedge clk);
    addr_a = 12'h112;
    @(negedge clk);
    chk(proto_err == 1'b1, "R8 error on address drift", proto_err, 1);
    strobe = 1'b0;
    repeat (2) @(negedge clk);
    window(1'b0, 12'h111, 12'h222, '0, "R8 later window");
    chk(proto_err == 1'b1, "R8 sticky", proto_err, 1);

    // R9 reset clears
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < DEPTH; k++) model[k] = '0;
    chk(proto_err == 1'b0 && rdata_a == '0, "R9 reset clears", {proto_err, rdata_a}, 0);
    window(1'b0, 12'h521, 12'h999, '0, "R9 cleared words");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule